// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Control Registers

This block keeps the bus-master control state for the two channels of a disk interface controller. Each channel has three registers: a command byte, a status byte and a 32-bit descriptor table pointer. Software reads and writes them over a simple register bus that carries byte and word accesses. The block turns changes of the start bit into single-cycle start and abort pulses toward a drive-side DMA engine, and each start pulse carries the channel's descriptor pointer.

The DMA engine reports back with a per-channel completion pulse and a per-channel error pulse. On completion the block ends the run in hardware, flags an interrupt and drives that channel's interrupt line. The block does not walk descriptors and does not implement the drive protocol. It only sequences the control and status bits.

Register window, 16 bytes. Byte offsets 0..7 belong to channel 0 and offsets 8..15 belong to channel 1. Within a channel:
- Offset 0 is the command byte: bit 0 is start, bit 3 is direction.
- Offset 1 is the status byte: bit 0 is active, bit 1 is error, bit 2 is interrupt, bits 5 and 6 are the two drive-capable flags.
- Offset 4 is the pointer.

The size code is 0 for a byte, 1 for a half-word and 2 for a word. Reads return one 32-bit word chosen by a 2-bit word index:
- Index 0 returns `{16'h0, status, command}` of channel 0.
- Index 1 returns the pointer of channel 0.
- Indices 2 and 3 return the same two words for channel 1.

Top module: `bmdma_regs`

## Requirements
- R1: After reset every command byte and pointer reads 0, and each status byte reads 0x60 (both drive-capable bits set, all other bits clear).
- R2: Every register write is ignored unless both `io_en` and `bm_en` are high.
- R3: The pointer is written only by a word-size (size code 2) write at channel offset 4, and bits 1:0 are stored as zero. Writes of any other size to that offset leave the pointer unchanged.
- R4: When a command write takes start from 0 to 1, the cycle after the write raises `start_pulse` for that channel for one cycle, sets active (status bit 0), and presents the pointer on `start_ptr`.
- R5: When a command write takes start from 1 to 0, the cycle after the write raises `abort_pulse` for one cycle and clears active.
- R6: While start is already 1, a command write keeps the old direction bit (command bit 3) and applies the rest of the written bits.
- R7: Active (status bit 0) ignores status writes and keeps its value.
- R8: Interrupt (status bit 2) and error (status bit 1) are cleared by writing 1 to them. Writing 0 leaves them unchanged, and no software write can set them. `dma_err` sets the error bit. The capability bits 6:5 take the written value.
- R9: A `dma_done` pulse clears start and active and sets interrupt, all at the same clock edge. It takes precedence over a start bit written in the same cycle, and it produces no abort pulse.
- R10: If `dma_done` arrives in the same cycle as a status write that clears interrupt, interrupt ends up set.
- R11: `irq[c]` is high exactly when channel c's interrupt bit is set.
- R12: Byte offsets below 8 address channel 0 and offsets 8 and above address channel 1. A write to one channel does not change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | I/O decode enable |
| bm_en | input | 1 | Bus-master enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte offset of the write |
| wr_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| wr_data | input | 32 | Write data, low byte used for byte writes |
| rd_word | input | 2 | Word index for reads |
| rd_data | output | 32 | Read data for the selected word |
| dma_done | input | 2 | Per-channel completion pulse from the DMA engine |
| dma_err | input | 2 | Per-channel error pulse from the DMA engine |
| start_pulse | output | 2 | Per-channel one-cycle start request |
| abort_pulse | output | 2 | Per-channel one-cycle abort request |
| start_ptr | output | 64 | Channel 1 pointer in bits 63:32, channel 0 pointer in bits 31:0 |
| irq | output | 2 | Per-channel interrupt line |

## Verification
Command writes are tried in three patterns: a start that sets the direction, a rewrite that tries to flip the direction mid-run, and a stop. A scoreboard separates start pulses from abort pulses and checks the pointer each start carries, which tells a correct edge detector from a level-triggered one. Status writes are tried with the interrupt and error bits written as 0 and then as 1, and also with bit 0 written as 0 during a run, which separates write-one-to-clear from plain storage and from a writable active bit. Completion is tried both alone and in the same cycle as a clearing status write, which shows whether the hardware set or the software clear wins.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int NCH      = 2;
  localparam int AW       = 4;
  localparam int DW       = 32;
  localparam int BIT_START = 0;
  localparam int BIT_DIR   = 3;
  localparam int BIT_ACT   = 0;
  localparam int BIT_ERR   = 1;
  localparam int BIT_INT   = 2;
  localparam logic [7:0] CAP_MASK  = 8'h60;
  localparam logic [7:0] STS_RESET = 8'h60;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;

  // new direction: locked while a run is in progress
  function automatic logic next_dir(input logic run, input logic old_dir, input logic [7:0] w);
    return run ? old_dir : w[BIT_DIR];
  endfunction

  // sticky flag with write-one-to-clear and a hardware set that wins
  function automatic logic w1c_flag(input logic old_v, input logic hw_set,
                                    input logic sw_we, input logic sw_bit);
    if (hw_set) return 1'b1;
    if (sw_we && sw_bit) return 1'b0;
    return old_v;
  endfunction

  function automatic logic [DW-1:0] align_ptr(input logic [DW-1:0] w);
    return {w[DW-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
(
  input  logic           io_en,
  input  logic           bm_en,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [1:0]     wr_size,
  output logic [NCH-1:0] cmd_we,
  output logic [NCH-1:0] sts_we,
  output logic [NCH-1:0] ptr_we
);
  localparam int OFS_W = AW - 1;
  logic wr_ok;
  logic [OFS_W-1:0] ofs;
  assign wr_ok = wr_en && io_en && bm_en;
  assign ofs   = wr_addr[OFS_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit       = wr_ok && (wr_addr[AW-1] == c[0]);
    assign cmd_we[c] = hit && (ofs == OFS_W'(0)) && (wr_size == SZ_BYTE);
    assign sts_we[c] = hit && (ofs == OFS_W'(1)) && (wr_size == SZ_BYTE);
    assign ptr_we[c] = hit && (ofs == OFS_W'(4)) && (wr_size == SZ_WORD);
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic          sts_we,
  input  logic          ptr_we,
  input  logic [DW-1:0] wdata,
  input  logic          done_i,
  input  logic          err_i,
  output logic [7:0]    cmd_o,
  output logic [7:0]    sts_o,
  output logic [DW-1:0] ptr_o,
  output logic          start_o,
  output logic          abort_o,
  output logic          irq_o
);
  logic run_q, dir_q, act_q, err_q, int_q;
  logic [1:0] cap_q;
  logic [DW-1:0] ptr_q;
  logic [7:0] wb;
  logic rise_ev, fall_ev;

  assign wb      = wdata[7:0];
  assign rise_ev = cmd_we && !run_q &&  wb[BIT_START] && !done_i;
  assign fall_ev = cmd_we &&  run_q && !wb[BIT_START] && !done_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      dir_q   <= 1'b0;
      act_q   <= 1'b0;
      err_q   <= 1'b0;
      int_q   <= 1'b0;
      cap_q   <= STS_RESET[6:5];
      ptr_q   <= '0;
      start_o <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      start_o <= rise_ev;
      abort_o <= fall_ev;
      if (cmd_we) dir_q <= next_dir(run_q, dir_q, wb);
      if (done_i)      run_q <= 1'b0;
      else if (cmd_we) run_q <= wb[BIT_START];
      if (done_i)       act_q <= 1'b0;
      else if (rise_ev) act_q <= 1'b1;
      else if (fall_ev) act_q <= 1'b0;
      int_q <= w1c_flag(int_q, done_i, sts_we, wb[BIT_INT]);
      err_q <= w1c_flag(err_q, err_i, sts_we, wb[BIT_ERR]);
      if (sts_we) cap_q <= wb[6:5];
      if (ptr_we) ptr_q <= align_ptr(wdata);
    end
  end

  assign cmd_o = {4'b0, dir_q, 2'b0, run_q};
  assign sts_o = {1'b0, cap_q, 2'b0, int_q, err_q, act_q};
  assign ptr_o = ptr_q;
  assign irq_o = int_q;

  // R4
  act_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> start_o);
  // R5
  act_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> (abort_o || $past(done_i)));
  // R6
  dir_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run_q) |-> $stable(dir_q));
  // R9
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (int_q && !run_q && !act_q));
  // R8
  int_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_q) |-> $past(done_i));
  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && abort_o));
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
  import bmdma_pkg::*;
(
  input  logic [NCH-1:0][7:0]    cmd_v,
  input  logic [NCH-1:0][7:0]    sts_v,
  input  logic [NCH-1:0][DW-1:0] ptr_v,
  input  logic [1:0]             rd_word,
  output logic [DW-1:0]          rd_data
);
  logic ch;
  assign ch = rd_word[1];
  always_comb begin
    if (rd_word[0]) rd_data = ptr_v[ch];
    else            rd_data = {16'h0, sts_v[ch], cmd_v[ch]};
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_en,
  input  logic               bm_en,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [1:0]         wr_size,
  input  logic [DW-1:0]      wr_data,
  input  logic [1:0]         rd_word,
  output logic [DW-1:0]      rd_data,
  input  logic [NCH-1:0]     dma_done,
  input  logic [NCH-1:0]     dma_err,
  output logic [NCH-1:0]     start_pulse,
  output logic [NCH-1:0]     abort_pulse,
  output logic [NCH*DW-1:0]  start_ptr,
  output logic [NCH-1:0]     irq
);
  logic [NCH-1:0] cmd_we, sts_we, ptr_we;
  logic [NCH-1:0][7:0] cmd_v, sts_v;
  logic [NCH-1:0][DW-1:0] ptr_v;

  bmdma_decode u_dec (
    .io_en(io_en), .bm_en(bm_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_size(wr_size), .cmd_we(cmd_we), .sts_we(sts_we), .ptr_we(ptr_we)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    bmdma_chan u_ch (
      .clk(clk), .rst_n(rst_n),
      .cmd_we(cmd_we[c]), .sts_we(sts_we[c]), .ptr_we(ptr_we[c]),
      .wdata(wr_data), .done_i(dma_done[c]), .err_i(dma_err[c]),
      .cmd_o(cmd_v[c]), .sts_o(sts_v[c]), .ptr_o(ptr_v[c]),
      .start_o(start_pulse[c]), .abort_o(abort_pulse[c]), .irq_o(irq[c])
    );
    assign start_ptr[c*DW +: DW] = ptr_v[c];
  end

  bmdma_rdmux u_rd (
    .cmd_v(cmd_v), .sts_v(sts_v), .ptr_v(ptr_v), .rd_word(rd_word), .rd_data(rd_data)
  );

  // R12
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_we, sts_we, ptr_we}));
  // R2
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_en || !bm_en) |-> ({cmd_we, sts_we, ptr_we} == '0));
endmodule

// File: tb/bmdma_regs_tb.sv
module bmdma_regs_tb;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0, io_en = 0, bm_en = 0, wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [1:0] wr_size = 0, rd_word = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [1:0] dma_done = 0, dma_err = 0, start_pulse, abort_pulse, irq;
  logic [63:0] start_ptr;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  typedef struct packed { logic ch; logic is_abort; logic [31:0] ptr; } ev_t;
  ev_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  bmdma_regs u_dut (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data), .rd_word(rd_word),
    .rd_data(rd_data), .dma_done(dma_done), .dma_err(dma_err),
    .start_pulse(start_pulse), .abort_pulse(abort_pulse), .start_ptr(start_ptr), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_size = sz; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] w, input logic [31:0] expv);
    rd_word = w; #1;
    check(tag, rd_data, expv);
  endtask

  task automatic pulse_in(input logic [1:0] dn, input logic [1:0] er);
    @(negedge clk);
    dma_done = dn; dma_err = er;
    @(negedge clk);
    dma_done = 0; dma_err = 0;
  endtask

  // monitor: pops expected pulse events from the scoreboard
  always @(negedge clk) if (rst_n) begin
    for (int c = 0; c < 2; c++) begin
      if (start_pulse[c] || abort_pulse[c]) begin
        n_run++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R4/R5 unexpected pulse ch%0d actual start=%b abort=%b expected none",
                   c, start_pulse[c], abort_pulse[c]);
        end else begin
          ev_t e, a;
          e = exp_q.pop_front();
          a.ch = c[0]; a.is_abort = abort_pulse[c];
          a.ptr = a.is_abort ? 32'h0 : start_ptr[c*32 +: 32];
          if (a !== e) begin
            n_fail++;
            $display("FAIL R4/R5 pulse actual=%h expected=%h", a, e);
          end
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    rd_chk("R1 ch0 word", 0, 32'h0000_6000);
    rd_chk("R1 ch0 ptr", 1, 32'h0);
    rd_chk("R1 ch1 word", 2, 32'h0000_6000);
    check("R11 irq reset", {30'h0, irq}, 32'h0);

    // R2 gating
    io_en = 1; bm_en = 0;
    wr(4'h4, 2'd2, 32'h1234_5678);
    wr(4'h0, 2'd0, 32'h09);
    rd_chk("R2 ptr unchanged bm_en=0", 1, 32'h0);
    rd_chk("R2 cmd unchanged bm_en=0", 0, 32'h0000_6000);
    io_en = 0; bm_en = 1;
    wr(4'h4, 2'd2, 32'h1234_5678);
    rd_chk("R2 ptr unchanged io_en=0", 1, 32'h0);
    io_en = 1;

    // R3 pointer alignment and size
    wr(4'h4, 2'd2, 32'h1000_0007);
    rd_chk("R3 ptr low bits zero", 1, 32'h1000_0004);
    wr(4'h4, 2'd0, 32'hFF);
    wr(4'h4, 2'd1, 32'hFFFF);
    rd_chk("R3 narrow ptr write ignored", 1, 32'h1000_0004);

    // R4 start with direction set
    exp_q.push_back('{ch: 1'b0, is_abort: 1'b0, ptr: 32'h1000_0004});
    wr(4'h0, 2'd0, 32'h09);
    rd_chk("R4 started, active set", 0, 32'h0000_6109);
    rd_chk("R12 ch1 untouched", 2, 32'h0000_6000);

    // R6 direction locked while running
    wr(4'h0, 2'd0, 32'h01);
    rd_chk("R6 dir kept", 0, 32'h0000_6109);

    // R7 active read-only
    wr(4'h1, 2'd0, 32'h60);
    rd_chk("R7 active kept", 0, 32'h0000_6109);

    // R5 stop
    exp_q.push_back('{ch: 1'b0, is_abort: 1'b1, ptr: 32'h0});
    wr(4'h0, 2'd0, 32'h00);
    rd_chk("R5 stopped, dir kept, active clear", 0, 32'h0000_6008);

    // R12 channel 1 start, R9 completion
    wr(4'hC, 2'd2, 32'hABCD_0002);
    rd_chk("R12 ch1 ptr", 3, 32'hABCD_0000);
    rd_chk("R12 ch0 ptr untouched", 1, 32'h1000_0004);
    exp_q.push_back('{ch: 1'b1, is_abort: 1'b0, ptr: 32'hABCD_0000});
    wr(4'h8, 2'd0, 32'h01);
    rd_chk("R4 ch1 started", 2, 32'h0000_6101);
    pulse_in(2'b10, 2'b00);
    rd_chk("R9 completion", 2, 32'h0000_6400);
    check("R11 irq ch1 high", {30'h0, irq}, 32'h2);

    // R8 write-one-to-clear
    wr(4'h9, 2'd0, 32'h60);
    rd_chk("R8 write 0 keeps intr", 2, 32'h0000_6400);
    wr(4'h9, 2'd0, 32'h64);
    rd_chk("R8 write 1 clears intr", 2, 32'h0000_6000);
    check("R11 irq low after clear", {30'h0, irq}, 32'h0);
    wr(4'h9, 2'd0, 32'h06);
    rd_chk("R8 software cannot set", 2, 32'h0000_0000);
    wr(4'h9, 2'd0, 32'h60);
    pulse_in(2'b00, 2'b01);
    rd_chk("R8 error set by engine", 0, 32'h0000_6208);
    wr(4'h1, 2'd0, 32'h60);
    rd_chk("R8 error write 0 keeps", 0, 32'h0000_6208);
    wr(4'h1, 2'd0, 32'h62);
    rd_chk("R8 error write 1 clears", 0, 32'h0000_6008);

    // R10 done vs software clear in the same cycle
    exp_q.push_back('{ch: 1'b1, is_abort: 1'b0, ptr: 32'hABCD_0000});
    wr(4'h8, 2'd0, 32'h01);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'h9; wr_size = 2'd0; wr_data = 32'h64; dma_done = 2'b10;
    @(negedge clk);
    wr_en = 0; dma_done = 0;
    rd_chk("R10 hw set wins", 2, 32'h0000_6400);
    check("R11 irq after race", {30'h0, irq}, 32'h2);

    // R9 done in the same cycle as a start write
    @(negedge clk);
    wr_en = 1; wr_addr = 4'h0; wr_size = 2'd0; wr_data = 32'h01; dma_done = 2'b01;
    @(negedge clk);
    wr_en = 0; dma_done = 0;
    rd_chk("R9 done beats start write", 0, 32'h0000_6400);

    repeat (3) @(negedge clk);
    check("R4/R5 scoreboard drained", exp_q.size(), 32'd0);
    summary();
  end
endmodule